// File: doc/BRIEF.md
# Shared-Factor Precoding Matrix Multiplier

This block produces a run of precoding matrices, one per user index, on a single multiply-accumulate datapath. Each result is the product of a per-user matrix (the already-inverted channel data) and a common factor matrix. The factor matrix is computed elsewhere, loaded once into a shared operand store, and then reused for every later user. Each iteration reloads only the per-user matrix. There are three storage arrays: the shared factor store, the per-user store, and a result store that the host reads back.

The host begins an iteration in idle by raising `op_we` and `op_sel` together. The word present on that cycle becomes element 0 of the first matrix loaded. Further words follow on later cycles with `op_we` high. If `reuse_shared` is high on the starting cycle and the factor store has been filled at least once since reset, the factor load is skipped and every word goes to the per-user store. Once the last per-user word is in, the controller works through the result elements in row-major order. For each element it makes DIM read-multiply-accumulate steps, waits one settle cycle, and writes one result word. After the last element it pulses `done` and advances `user_idx`.

Top module: `shared_factor_precoder`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `done` is 0 and `user_idx` equals FIRST_IDX (default 4).
- R2: In idle, a cycle with `op_we` high and `op_sel` low is ignored. No iteration starts, no storage changes, and `done` and `user_idx` are unaffected. Only `op_we` and `op_sel` both high start an iteration.
- R3: Without reuse, the starting word and the next DIM*DIM-1 accepted words fill the shared factor matrix A in row-major order (address row*DIM+col). The following DIM*DIM accepted words fill the per-user matrix B in the same order.
- R4: With `reuse_shared` high on the starting cycle, after A has been filled at least once, the starting word and the following words go only to B. A keeps its earlier contents.
- R5: During loading, a word is accepted only on a cycle with `op_we` high. Cycles with `op_we` low do not advance the load.
- R6: Result element (r,c) equals the signed sum over k of B[r][k]*A[k][c], at full precision (2*DW+log2(DIM) bits, signed). It is stored at address r*DIM+c. Setting `res_addr` makes the word appear on `res_data` one clock later.
- R7: The accumulator restarts for every result element, so no element carries any part of an earlier element or an earlier iteration.
- R8: After the last result element is written, `done` is high for exactly one cycle, and the block then returns to idle.
- R9: `user_idx` increases by exactly one on the cycle `done` is high, and at no other time.
- R10: If `reuse_shared` is requested before A has ever been filled since reset, the block loads A anyway, as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_we | input | 1 | Operand word valid |
| op_sel | input | 1 | With op_we in idle, starts an iteration |
| op_data | input | DW | Signed operand word |
| reuse_shared | input | 1 | Skip the shared factor load when A is already filled |
| res_addr | input | 2*log2(DIM) | Result read address, row*DIM+col |
| res_data | output | 2*DW+log2(DIM) | Signed result word, one-cycle read latency |
| done | output | 1 | One-cycle pulse when a precoder is complete |
| user_idx | output | IDX_W | User index of the next precoder to be produced |

## Verification
A load counter that drifts by one word, or that advances on stalled cycles, moves every operand of a matrix by one place. This shows up in almost every result word of that iteration, and `done` arrives one accepted word early or late. A wrong skip decision sends per-user data into the shared store and corrupts that iteration and every later reuse iteration. A stale accumulator or a wrong read address pairing corrupts individual result elements as soon as the iteration's results are read back. Errors in the state sequence show as a `done` that never arrives, repeats, or lands out of step with `user_idx`.

// File: rtl/spf_pkg.sv
package spf_pkg;
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_LDA  = 3'd1,
    S_LDB  = 3'd2,
    S_MAC  = 3'd3,
    S_SAVE = 3'd4,
    S_WRC  = 3'd5,
    S_DONE = 3'd6
  } spf_state_e;
endpackage

// File: rtl/spf_ram.sv
module spf_ram #(
  parameter int W  = 16,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/spf_mac.sv
module spf_mac #(
  parameter int DW    = 16,
  parameter int ACC_W = 37
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    first,
  input  logic signed [DW-1:0]    a,
  input  logic signed [DW-1:0]    b,
  output logic signed [ACC_W-1:0] acc
);
  localparam int PW = 2 * DW;

  logic signed [PW-1:0]    prod;
  logic signed [ACC_W-1:0] prod_ext;

  assign prod     = a * b;
  assign prod_ext = {{(ACC_W-PW){prod[PW-1]}}, prod};

  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else if (en) acc <= (first ? '0 : acc) + prod_ext;
  end
endmodule

// File: rtl/spf_ctrl.sv
module spf_ctrl
  import spf_pkg::*;
#(
  parameter int DIM       = 32,
  parameter int IDX_W     = 8,
  parameter int FIRST_IDX = 4,
  localparam int KW = $clog2(DIM),
  localparam int AW = 2 * KW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_we,
  input  logic             op_sel,
  input  logic             reuse,
  output logic             a_we,
  output logic             b_we,
  output logic [AW-1:0]    wr_addr,
  output logic [AW-1:0]    a_raddr,
  output logic [AW-1:0]    b_raddr,
  output logic             mac_en,
  output logic             mac_first,
  output logic             c_we,
  output logic [AW-1:0]    c_addr,
  output logic             done,
  output logic [IDX_W-1:0] user_idx,
  output spf_state_e       st,
  output logic             a_loaded
);
  localparam logic [AW-1:0] LAST_W = AW'((DIM * DIM) - 1);
  localparam logic [KW-1:0] LAST_K = KW'(DIM - 1);

  spf_state_e    state;
  logic [AW-1:0] wcnt;
  logic [AW-1:0] elem;
  logic [KW-1:0] k;
  logic          go;
  logic          skip;

  assign go   = op_we & op_sel;
  assign skip = reuse & a_loaded;

  assign a_we    = ((state == S_IDLE) & go & ~skip) | ((state == S_LDA) & op_we);
  assign b_we    = ((state == S_IDLE) & go & skip)  | ((state == S_LDB) & op_we);
  assign wr_addr = wcnt;
  assign a_raddr = {k, elem[KW-1:0]};
  assign b_raddr = {elem[AW-1:KW], k};
  assign c_we    = (state == S_WRC);
  assign c_addr  = elem;
  assign st      = state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      wcnt      <= '0;
      elem      <= '0;
      k         <= '0;
      a_loaded  <= 1'b0;
      mac_en    <= 1'b0;
      mac_first <= 1'b0;
      done      <= 1'b0;
      user_idx  <= IDX_W'(FIRST_IDX);
    end else begin
      done      <= 1'b0;
      mac_en    <= (state == S_MAC);
      mac_first <= (state == S_MAC) && (k == '0);
      case (state)
        S_IDLE: begin
          if (go) begin
            wcnt  <= AW'(1);
            state <= skip ? S_LDB : S_LDA;
          end
        end
        S_LDA: begin
          if (op_we) begin
            if (wcnt == LAST_W) begin
              wcnt     <= '0;
              a_loaded <= 1'b1;
              state    <= S_LDB;
            end else begin
              wcnt <= wcnt + AW'(1);
            end
          end
        end
        S_LDB: begin
          if (op_we) begin
            if (wcnt == LAST_W) begin
              wcnt  <= '0;
              elem  <= '0;
              k     <= '0;
              state <= S_MAC;
            end else begin
              wcnt <= wcnt + AW'(1);
            end
          end
        end
        S_MAC: begin
          k <= k + KW'(1);
          if (k == LAST_K) state <= S_SAVE;
        end
        S_SAVE: state <= S_WRC;
        S_WRC: begin
          if (elem == LAST_W) begin
            done     <= 1'b1;
            user_idx <= user_idx + IDX_W'(1);
            state    <= S_DONE;
          end else begin
            elem  <= elem + AW'(1);
            state <= S_MAC;
          end
        end
        S_DONE: begin
          elem  <= '0;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/shared_factor_precoder.sv
module shared_factor_precoder
  import spf_pkg::*;
#(
  parameter int DIM       = 32,
  parameter int DW        = 16,
  parameter int IDX_W     = 8,
  parameter int FIRST_IDX = 4,
  localparam int KW    = $clog2(DIM),
  localparam int AW    = 2 * KW,
  localparam int ACC_W = 2 * DW + KW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_we,
  input  logic             op_sel,
  input  logic [DW-1:0]    op_data,
  input  logic             reuse_shared,
  input  logic [AW-1:0]    res_addr,
  output logic [ACC_W-1:0] res_data,
  output logic             done,
  output logic [IDX_W-1:0] user_idx
);
  logic          a_we, b_we, c_we;
  logic [AW-1:0] wr_addr, a_raddr, b_raddr, c_addr;
  logic          mac_en, mac_first;
  logic [DW-1:0] a_q, b_q;
  logic signed [ACC_W-1:0] acc;
  spf_state_e    st;
  logic          a_loaded;

  spf_ctrl #(.DIM(DIM), .IDX_W(IDX_W), .FIRST_IDX(FIRST_IDX)) ctrl_i (
    .clk(clk), .rst(rst), .op_we(op_we), .op_sel(op_sel), .reuse(reuse_shared),
    .a_we(a_we), .b_we(b_we), .wr_addr(wr_addr),
    .a_raddr(a_raddr), .b_raddr(b_raddr),
    .mac_en(mac_en), .mac_first(mac_first),
    .c_we(c_we), .c_addr(c_addr),
    .done(done), .user_idx(user_idx), .st(st), .a_loaded(a_loaded)
  );

  spf_ram #(.W(DW), .AW(AW)) ram_shared_i (
    .clk(clk), .we(a_we), .waddr(wr_addr), .wdata(op_data),
    .raddr(a_raddr), .rdata(a_q)
  );

  spf_ram #(.W(DW), .AW(AW)) ram_user_i (
    .clk(clk), .we(b_we), .waddr(wr_addr), .wdata(op_data),
    .raddr(b_raddr), .rdata(b_q)
  );

  spf_mac #(.DW(DW), .ACC_W(ACC_W)) mac_i (
    .clk(clk), .rst(rst), .en(mac_en), .first(mac_first),
    .a($signed(a_q)), .b($signed(b_q)), .acc(acc)
  );

  spf_ram #(.W(ACC_W), .AW(AW)) ram_result_i (
    .clk(clk), .we(c_we), .waddr(c_addr), .wdata(acc),
    .raddr(res_addr), .rdata(res_data)
  );
endmodule

// File: rtl/spf_chk.sv
module spf_chk
  import spf_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             op_we,
  input logic             op_sel,
  input logic             reuse_shared,
  input logic             done,
  input logic [IDX_W-1:0] user_idx,
  input spf_state_e       st,
  input logic             a_loaded
);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);

  // R8
  done_state_chk: assert property (@(posedge clk) disable iff (rst) done |-> st == S_DONE);

  // R9
  idx_step_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> user_idx == IDX_W'($past(user_idx) + 1'b1));

  // R9
  idx_hold_chk: assert property (@(posedge clk) disable iff (rst) !done |-> $stable(user_idx));

  // R2
  idle_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && op_we && !op_sel) |=> st == S_IDLE);

  // R5
  load_stall_chk: assert property (@(posedge clk) disable iff (rst)
    ((st == S_LDA || st == S_LDB) && !op_we) |=> $stable(st));

  // R4
  reuse_skip_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && op_we && op_sel && reuse_shared && a_loaded) |=> st == S_LDB);

  // R10
  first_load_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && op_we && op_sel && !a_loaded) |=> st == S_LDA);
endmodule

bind shared_factor_precoder spf_chk #(.IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst(rst), .op_we(op_we), .op_sel(op_sel),
  .reuse_shared(reuse_shared), .done(done), .user_idx(user_idx),
  .st(st), .a_loaded(a_loaded)
);

// File: tb/shared_factor_precoder_tb_top.sv
module shared_factor_precoder_tb_top;
  localparam int N   = 4;
  localparam int N2  = N * N;
  localparam int DW  = 16;
  localparam int AW  = 4;
  localparam int ACW = 34;
  localparam int IW  = 8;

  // seed_a, seed_b, reuse, stall gaps
  localparam int VEC [5][4] = '{
    '{3, 11, 0, 0},
    '{3, 12, 1, 0},
    '{9,  4, 0, 1},
    '{9,  5, 1, 1},
    '{0,  0, 0, 0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic op_we = 1'b0, op_sel = 1'b0, reuse_shared = 1'b0;
  logic [DW-1:0]  op_data = '0;
  logic [AW-1:0]  res_addr = '0;
  logic [ACW-1:0] res_data;
  logic           done;
  logic [IW-1:0]  user_idx;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  bit tb_a_loaded = 1'b0;
  int exp_idx = 4;
  logic signed [DW-1:0] mA [N2];
  logic signed [DW-1:0] mB [N2];

  always #5 clk = ~clk;

  shared_factor_precoder #(.DIM(N), .DW(DW), .IDX_W(IW), .FIRST_IDX(4)) dut_i (
    .clk(clk), .rst(rst), .op_we(op_we), .op_sel(op_sel), .op_data(op_data),
    .reuse_shared(reuse_shared), .res_addr(res_addr), .res_data(res_data),
    .done(done), .user_idx(user_idx)
  );

  function automatic logic signed [DW-1:0] gen(int seed, int idx);
    if (seed == 0) return 16'sh8000;
    return DW'((seed * 7919) + (idx * (seed + 3) * 131) + (idx * idx * 29) - 20000);
  endfunction

  task automatic check(bit ok, string req, longint act, longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic send_word(logic [DW-1:0] w, bit sel, bit reuse, bit gap);
    if (gap) begin
      op_we = 1'b0; op_sel = 1'b0; op_data = 16'h5A5A;
      @(negedge clk);
    end
    op_we = 1'b1; op_sel = sel; reuse_shared = reuse; op_data = w;
    @(negedge clk);
    op_we = 1'b0; op_sel = 1'b0; reuse_shared = 1'b0;
  endtask

  task automatic run_iter(int sa, int sb, bit reuse, bit gap, bit send_a, string tag);
    bit first = 1'b1;
    bit seen = 1'b0;
    if (send_a) begin
      for (int i = 0; i < N2; i++) begin
        mA[i] = gen(sa, i);
        send_word(mA[i], first, reuse, gap);
        first = 1'b0;
      end
      tb_a_loaded = 1'b1;
    end
    for (int i = 0; i < N2; i++) begin
      mB[i] = gen(sb, i);
      send_word(mB[i], first, reuse, gap);
      first = 1'b0;
    end
    for (int t = 0; t < 400 && !seen; t++) begin
      if (done) seen = 1'b1;
      else @(negedge clk);
    end
    check(seen, {tag, " R8 done arrives"}, seen, 1);
    if (seen) begin
      exp_idx++;
      // R9: index advanced with done
      check(user_idx == IW'(exp_idx), {tag, " R9 user_idx"}, user_idx, exp_idx);
      @(negedge clk);
      // R8: single-cycle pulse
      check(!done, {tag, " R8 done width"}, done, 0);
    end
    for (int e = 0; e < N2; e++) begin
      longint s = 0;
      logic signed [ACW-1:0] expv;
      for (int kk = 0; kk < N; kk++)
        s += longint'(mB[(e / N) * N + kk]) * longint'(mA[kk * N + (e % N)]);
      expv = ACW'(s);
      res_addr = AW'(e);
      @(negedge clk);
      // R6 R7: each element is an independent full-precision dot product
      check($signed(res_data) == expv, {tag, " R6/R7 result"}, $signed(res_data), expv);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    check(done == 1'b0, "R1 done in reset", done, 0);
    check(user_idx == 8'd4, "R1 user_idx in reset", user_idx, 4);
    rst = 1'b0;
    @(negedge clk);
    check(done == 1'b0 && user_idx == 8'd4, "R1 after reset", user_idx, 4);

    for (int v = 0; v < 5; v++) begin
      bit rz = VEC[v][2] != 0;
      // R3 R4 R5: load path selected by reuse; stalls inserted when gap set
      run_iter(VEC[v][0], VEC[v][1], rz, VEC[v][3] != 0, !(rz && tb_a_loaded), "vec");
    end

    // R2: op_we without op_sel in idle has no effect
    for (int i = 0; i < 3; i++) begin
      op_we = 1'b1; op_sel = 1'b0; op_data = 16'h7FFF;
      @(negedge clk);
    end
    op_we = 1'b0;
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R2 no start", done, 0);
    check(user_idx == IW'(exp_idx), "R2 index held", user_idx, exp_idx);
    // R2 R4: A (all -32768) kept, proper start still works
    run_iter(0, 21, 1'b1, 1'b0, 1'b0, "R2R4");

    // R10: after reset, reuse request must still load A
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    exp_idx = 4;
    tb_a_loaded = 1'b0;
    check(user_idx == 8'd4, "R1 index after second reset", user_idx, 4);
    run_iter(17, 6, 1'b1, 1'b0, 1'b1, "R10");
    run_iter(17, 8, 1'b1, 1'b1, 1'b0, "R4 reuse after R10");

    finish_run();
  end
endmodule